// File: doc/BRIEF.md
# Accumulator Store Rounding and Write-Back Unit

This unit prepares a 40-bit accumulator value for a 16-bit store. It takes the signed fractional word in bits 31:16, optionally rounds it using the low word in bits 15:0, and clamps it to the 1.15 range. It also works out where the result goes. The result can go into the pointer register itself, or into memory at the address the pointer holds, with the pointer then advanced by one word.

Two kinds of operation use the unit. A store takes the accumulator that the instruction names, and the instruction chooses rounding or truncation. A multiply-accumulate write-back takes the other accumulator, the one the operation does not update, and always rounds it. A write-back operation can be flagged as having no write-back, in which case nothing is written.

All outputs are registered, so a result appears one clock after the operation is presented.

Top module: `acc_store_unit`

## Requirements
- R1: Conventional rounding (rnd_mode_i = 0): the high word is incremented when bit 15 of the accumulator is 1 (low word 0x8000 to 0xFFFF). It is unchanged when the low word is 0x0000 to 0x7FFF.
- R2: Convergent rounding (rnd_mode_i = 1): when the low word is exactly 0x8000, the high word is incremented only if accumulator bit 16 is 1.
- R3: For every low word other than 0x8000, convergent rounding gives the same result as conventional rounding.
- R4: A store (op_kind_i = 0) with round_en_i = 0 writes accumulator bits 31:16 unchanged and discards the low word.
- R5: After rounding, if bits 39 down to 31 are not all equal, the data is 0x7FFF for a non-negative source (bit 39 = 0) and 0x8000 for a negative one. This includes a carry from the rounding increment that wraps the top bit.
- R6: A write-back (op_kind_i = 1) takes oth_acc_i, never tgt_acc_i, and is rounded whatever the value of round_en_i.
- R7: Direct mode (wb_mode_i = 0): to_reg_o = 1, and the pointer is written with the data itself (ptr_o = data_o, ptr_we_o = 1).
- R8: Indirect mode (wb_mode_i = 1): addr_o = ptr_i and to_reg_o = 0. The pointer is written with ptr_i + 2, modulo 2^16.
- R9: A write-back with wb_skip_i = 1 gives we_o = 0 and ptr_we_o = 0, and ptr_o equals ptr_i.
- R10: Outputs appear one clock after the operation is presented with op_valid_i = 1. While reset is asserted, and in cycles with no operation, we_o and ptr_we_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_kind_i | input | 1 | 0 = store of the target accumulator, 1 = write-back of the other accumulator |
| round_en_i | input | 1 | Round a store (ignored for write-back) |
| rnd_mode_i | input | 1 | 0 = conventional, 1 = convergent |
| wb_skip_i | input | 1 | The write-back operation has no write-back |
| wb_mode_i | input | 1 | 0 = register direct, 1 = indirect with post-increment |
| tgt_acc_i | input | 40 | Accumulator named by the operation |
| oth_acc_i | input | 40 | The other accumulator |
| ptr_i | input | 16 | Current pointer register value |
| we_o | output | 1 | Write strobe |
| to_reg_o | output | 1 | The destination is the pointer register |
| addr_o | output | 16 | Memory address for an indirect write |
| data_o | output | 16 | Saturated 1.15 data |
| ptr_we_o | output | 1 | Pointer register update strobe |
| ptr_o | output | 16 | Next pointer value |

## Verification
If the increment decision is wrong, data_o is off by one exactly at the rounding boundaries. The low words 0x7FFF, 0x8000 and 0x8001, combined with both values of bit 16, expose this one clock after the operation. A wrong saturation check shows up as a wrapped sign, for example 0x8000 in place of 0x7FFF, when rounding carries out of 0x7FFF. If the two accumulators are swapped or the address path is wrong, data_o, addr_o or ptr_o no longer match in that same cycle. A skipped write-back that still strobes the write is visible at we_o.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
  typedef enum logic {
    WB_DIRECT   = 1'b0,
    WB_POST_INC = 1'b1
  } wb_mode_e;

  typedef enum logic {
    RND_CONV = 1'b0,
    RND_UNBIASED = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/acc_round.sv
module acc_round #(
  parameter int ACC_W  = 40,
  parameter int DATA_W = 16,
  localparam int HI_W  = ACC_W - DATA_W
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rnd_en_i,
  input  logic             unbiased_i,
  output logic [HI_W-1:0]  hi_o,
  output logic             sign_o
);
  localparam logic [DATA_W-1:0] TIE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] lo;
  logic              tie, inc;

  assign lo     = acc_i[DATA_W-1:0];
  assign tie    = (lo == TIE);
  // exact tie under unbiased mode: round toward even (bit DATA_W)
  assign inc    = rnd_en_i && lo[DATA_W-1] && !(unbiased_i && tie && !acc_i[DATA_W]);
  assign hi_o   = acc_i[ACC_W-1:DATA_W] + HI_W'(inc);
  assign sign_o = acc_i[ACC_W-1];
endmodule

// File: rtl/data_sat.sv
module data_sat #(
  parameter int ACC_W  = 40,
  parameter int DATA_W = 16,
  localparam int HI_W  = ACC_W - DATA_W,
  localparam int CHK_W = HI_W - DATA_W + 1
) (
  input  logic [HI_W-1:0]   hi_i,
  input  logic              sign_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CHK_W-1:0] chk;
  logic             ovf;

  assign chk = hi_i[HI_W-1:DATA_W-1];
  assign ovf = !((chk == '0) || (chk == '1));

  always_comb begin
    if (!ovf)        data_o = hi_i[DATA_W-1:0];
    else if (sign_i) data_o = MAX_NEG;
    else             data_o = MAX_POS;
  end
endmodule

// File: rtl/wb_addr_gen.sv
module wb_addr_gen
  import acc_store_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int PTR_STEP = 2
) (
  input  wb_mode_e          mode_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              to_reg_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] ptr_nxt_o
);
  always_comb begin
    to_reg_o  = (mode_i == WB_DIRECT);
    addr_o    = ptr_i;
    if (mode_i == WB_DIRECT) ptr_nxt_o = ADDR_W'(data_i);
    else                     ptr_nxt_o = ptr_i + ADDR_W'(PTR_STEP);
  end
endmodule

// File: rtl/acc_store_unit.sv
module acc_store_unit
  import acc_store_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int PTR_STEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_kind_i,
  input  logic              round_en_i,
  input  logic              rnd_mode_i,
  input  logic              wb_skip_i,
  input  logic              wb_mode_i,
  input  logic [ACC_W-1:0]  tgt_acc_i,
  input  logic [ACC_W-1:0]  oth_acc_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              we_o,
  output logic              to_reg_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ptr_we_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W  = ACC_W - DATA_W;
  localparam int TOP_W = ACC_W - 2*DATA_W + 1;

  logic [ACC_W-1:0]  src_acc;
  logic              do_rnd, do_wr, sign;
  logic [HI_W-1:0]   rnd_hi;
  logic [DATA_W-1:0] sat_data;
  logic              to_reg_c;
  logic [ADDR_W-1:0] addr_c, ptr_nxt_c;

  assign src_acc = op_kind_i ? oth_acc_i : tgt_acc_i;
  assign do_rnd  = op_kind_i | round_en_i;
  assign do_wr   = op_valid_i & ~(op_kind_i & wb_skip_i);

  acc_round #(.ACC_W(ACC_W), .DATA_W(DATA_W)) i_round (
    .acc_i      (src_acc),
    .rnd_en_i   (do_rnd),
    .unbiased_i (rnd_mode_i),
    .hi_o       (rnd_hi),
    .sign_o     (sign)
  );

  data_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W)) i_sat (
    .hi_i   (rnd_hi),
    .sign_i (sign),
    .data_o (sat_data)
  );

  wb_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_STEP(PTR_STEP)) i_addr (
    .mode_i    (wb_mode_e'(wb_mode_i)),
    .ptr_i     (ptr_i),
    .data_i    (sat_data),
    .to_reg_o  (to_reg_c),
    .addr_o    (addr_c),
    .ptr_nxt_o (ptr_nxt_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o     <= 1'b0;
      to_reg_o <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
      ptr_we_o <= 1'b0;
      ptr_o    <= '0;
    end else begin
      we_o     <= do_wr;
      ptr_we_o <= do_wr;
      to_reg_o <= to_reg_c;
      addr_o   <= addr_c;
      data_o   <= sat_data;
      ptr_o    <= do_wr ? ptr_nxt_c : ptr_i;
    end
  end

  AST_DIRECT_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_o && to_reg_o) |-> (ptr_o == ADDR_W'(data_o))); // R7

  AST_POST_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_o && !to_reg_o) |-> (ptr_o == addr_o + ADDR_W'(PTR_STEP))); // R8

  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_valid_i && op_kind_i && wb_skip_i) |-> (!we_o && !ptr_we_o && ptr_o == $past(ptr_i))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!op_valid_i) |-> (!we_o && !ptr_we_o)); // R10

  AST_TRUNC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_valid_i && !op_kind_i && !round_en_i &&
          ((tgt_acc_i[ACC_W-1:2*DATA_W-1] == {TOP_W{1'b0}}) ||
           (tgt_acc_i[ACC_W-1:2*DATA_W-1] == {TOP_W{1'b1}})))
    |-> (data_o == $past(tgt_acc_i[2*DATA_W-1:DATA_W]))); // R4
endmodule

// File: tb/test_acc_store_unit.sv
module test_acc_store_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0, op_kind_i = 1'b0, round_en_i = 1'b0;
  logic        rnd_mode_i = 1'b0, wb_skip_i = 1'b0, wb_mode_i = 1'b1;
  logic [39:0] tgt_acc_i = '0, oth_acc_i = '0;
  logic [15:0] ptr_i = '0;
  logic        we_o, to_reg_o, ptr_we_o;
  logic [15:0] addr_o, data_o, ptr_o;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  acc_store_unit i_acc_store_unit (.*);

  // {kind, round_en, mode, acc[39:0], expected data}
  localparam int NV = 15;
  localparam logic [58:0] VEC [NV] = '{
    {3'b000, 40'h00_1234_FFFF, 16'h1234},  // R4 truncate
    {3'b010, 40'h00_1234_8000, 16'h1235},  // R1 conv up at 0x8000
    {3'b010, 40'h00_1234_7FFF, 16'h1234},  // R1 conv no change
    {3'b011, 40'h00_1234_8000, 16'h1234},  // R2 tie, bit16=0
    {3'b011, 40'h00_1235_8000, 16'h1236},  // R2 tie, bit16=1
    {3'b011, 40'h00_1234_8001, 16'h1235},  // R3 non-tie same as conv
    {3'b011, 40'h00_1234_7FFF, 16'h1234},  // R3 non-tie below
    {3'b010, 40'h00_7FFF_8000, 16'h7FFF},  // R5 round carry into bit 31
    {3'b010, 40'hFF_FFFF_8000, 16'h0000},  // R1 negative rounds to zero
    {3'b000, 40'hFF_8000_0000, 16'h8000},  // R4 most negative in range
    {3'b000, 40'hFF_7FFF_FFFF, 16'h8000},  // R5 negative overflow
    {3'b000, 40'h01_0000_0000, 16'h7FFF},  // R5 positive overflow
    {3'b010, 40'h7F_FFFF_8000, 16'h7FFF},  // R5 carry wraps bit 39
    {3'b000, 40'hFF_ABCD_FFFF, 16'hABCD},  // R4 negative truncate
    {3'b111, 40'h00_1235_8000, 16'h1236}   // R6 write-back rounds
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic kind, input logic rnd, input logic mode,
                       input logic skip, input logic wbm,
                       input logic [39:0] tgt, input logic [39:0] oth,
                       input logic [15:0] ptr);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_kind_i = kind; round_en_i = rnd; rnd_mode_i = mode;
    wb_skip_i = skip; wb_mode_i = wbm; tgt_acc_i = tgt; oth_acc_i = oth; ptr_i = ptr;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R10 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset we", 16'(we_o), 16'h0);
    chk("R10 reset ptr_we", 16'(ptr_we_o), 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      // write-back rows: the named accumulator carries a decoy value
      if (VEC[i][58])
        issue(1'b1, 1'b0, VEC[i][56], 1'b0, 1'b1, 40'h00_5555_0000, VEC[i][55:16], 16'h0040);
      else
        issue(1'b0, VEC[i][57], VEC[i][56], 1'b0, 1'b1, VEC[i][55:16], 40'h00_5555_0000, 16'h0040);
      chk($sformatf("vec %0d data", i), data_o, VEC[i][15:0]);
      chk("R10 strobe", 16'(we_o), 16'h1);
    end

    // R6: write-back ignores round_en_i=0 and takes oth_acc_i
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 40'h00_4444_0000, 40'h00_0100_C000, 16'h0200);
    chk("R6 other acc rounded", data_o, 16'h0101);

    // R8: indirect address and post-increment
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 40'h00_2222_0000, '0, 16'h0100);
    chk("R8 addr", addr_o, 16'h0100);
    chk("R8 ptr", ptr_o, 16'h0102);
    chk("R8 to_reg", 16'(to_reg_o), 16'h0);
    chk("R8 ptr_we", 16'(ptr_we_o), 16'h1);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0, 40'h00_0001_0000, 16'hFFFE);
    chk("R8 ptr wrap", ptr_o, 16'h0000);

    // R7: register direct
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_3333_8000, '0, 16'h0800);
    chk("R7 to_reg", 16'(to_reg_o), 16'h1);
    chk("R7 ptr gets data", ptr_o, 16'h3334);
    chk("R7 ptr_we", 16'(ptr_we_o), 16'h1);

    // R9: skipped write-back
    issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0, 40'h00_1111_0000, 16'h0500);
    chk("R9 we", 16'(we_o), 16'h0);
    chk("R9 ptr_we", 16'(ptr_we_o), 16'h0);
    chk("R9 ptr held", ptr_o, 16'h0500);

    // R10: idle cycle gives no strobe
    @(negedge clk_i);
    op_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R10 idle we", 16'(we_o), 16'h0);
    chk("R10 idle ptr_we", 16'(ptr_we_o), 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule